// File: doc/BRIEF.md
# Trace Capture Ring Buffer

This block is a trace sink that records a stream of 32-bit trace words into an on-chip RAM used as a circular store. Trace words arrive on a valid/ready stream. A trigger input and a flush-request input control when capture ends. Software reaches the block through a simple 32-bit register bus. Through that bus it arms capture, programs the stop conditions, moves the two RAM pointers and drains the stored words.

When capture ends because of a flush or a trigger, a small formatter first fills the RAM with zero words up to the next frame boundary, then raises a stopped flag. The frame is 4 words by default. A sticky wrap flag tells software where the oldest word lives. If the flag is set, the oldest word is at the write pointer. If it is clear, the oldest word is at address 0. Software therefore loads the read pointer from that position and reads the data register repeatedly, and the words come out oldest first, aligned to frames.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset the wrap flag (status offset 0x00C bit 0) is 0, the stopped flag (formatter status offset 0x300 bit 1) is 1, both pointers read 0, the control register reads 0 and `tr_ready` is low.
- R2: Offset 0x004 reads the RAM depth in words with bit 31 clear; a bus write there changes nothing.
- R3: While control bit 0 (offset 0x020) is 0, a write to offset 0x024 stores the word at the write pointer and advances it, and a write to offset 0x018 loads the write pointer. A read of offset 0x010 returns the word at the read pointer and advances it, and a write to 0x014 loads the read pointer. Both pointers wrap modulo the depth. While control bit 0 is 1, writes to 0x018 and 0x024 are ignored.
- R4: While capture is armed and not stopped, `tr_ready` is high and every accepted word is stored at the write pointer, which then advances.
- R5: The wrap flag becomes 1 when a trace-path write lands on the last RAM address, and it stays 1 until capture is re-armed.
- R6: Writing control bit 0 from 0 to 1 clears the stopped flag, the wrap flag and the trigger-seen state, and reloads the post-trigger counter from offset 0x01C.
- R7: With formatter control (offset 0x304) bit 13 set, exactly N further words are accepted after the cycle in which `trig_in` is seen, where N is the value at 0x01C. Capture then stops.
- R8: With bit 13 clear, a trigger does not affect capture.
- R9: A flush request (writing 1 to 0x304 bit 6, or pulsing `flush_in`) with 0x304 bit 0 set writes zero words until the write pointer is a multiple of the frame size. Bit 6 reads 1 until the flush is complete, then clears itself.
- R10: When a flush completes with 0x304 bit 12 set, capture stops. With bit 12 clear, capture resumes.
- R11: With 0x304 bit 0 clear, a stop or flush takes effect with no zero fill.
- R12: Writing 0 to control bit 0 drops `tr_ready` at once and sets the stopped flag.
- R13: A flush requested while control bit 0 is 0 completes at once, and bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tr_valid | input | 1 | Trace word offered |
| tr_data | input | 32 | Trace word |
| tr_ready | output | 1 | Trace word accepted when high with `tr_valid` |
| trig_in | input | 1 | Trigger event |
| flush_in | input | 1 | Flush request pulse |

## Verification
The bench sweeps every start alignment inside a frame against post-trigger counts from 0 to 6. A counter that is off by one, or a stop that skips the zero fill, shows up there as a wrong accepted-word count or a final write pointer that is not frame aligned. It fills the ring past its end. A design that set the wrap flag one word early or late, or that drained from the wrong oldest position, would return the words out of order. It also checks that the zero fill really overwrites stale RAM words, that the flush bit stays high while filling and clears afterwards, and that a flush while disarmed finishes at once instead of hanging.

// File: rtl/trs_pkg.sv
package trs_pkg;

   localparam int BUS_AW = 12;

   localparam logic [BUS_AW-1:0] OFS_DEPTH = 12'h004;
   localparam logic [BUS_AW-1:0] OFS_STAT  = 12'h00C;
   localparam logic [BUS_AW-1:0] OFS_RDAT  = 12'h010;
   localparam logic [BUS_AW-1:0] OFS_RPTR  = 12'h014;
   localparam logic [BUS_AW-1:0] OFS_WPTR  = 12'h018;
   localparam logic [BUS_AW-1:0] OFS_TCNT  = 12'h01C;
   localparam logic [BUS_AW-1:0] OFS_CTRL  = 12'h020;
   localparam logic [BUS_AW-1:0] OFS_WDAT  = 12'h024;
   localparam logic [BUS_AW-1:0] OFS_FSTAT = 12'h300;
   localparam logic [BUS_AW-1:0] OFS_FCTRL = 12'h304;

   // formatter control / status bit positions
   localparam int FC_EN      = 0;
   localparam int FC_FLUSH   = 6;
   localparam int FC_STOPFL  = 12;
   localparam int FC_STOPTR  = 13;
   localparam int FS_STOPPED = 1;

   typedef enum logic [1:0] {
      FMT_RUN  = 2'd0,
      FMT_PAD  = 2'd1,
      FMT_HALT = 2'd2
   } fmt_state_e;

   typedef struct packed {
      logic fmt_en;
      logic stop_fl;
      logic stop_tr;
   } fmt_cfg_t;

endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
   parameter int DEPTH = 1024,
   parameter int DW    = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/trs_fmt.sv
module trs_fmt
   import trs_pkg::*;
#(
   parameter int CW   = 16,
   parameter int FA_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctrl_en,
   input  logic            start,
   input  fmt_cfg_t        cfg,
   input  logic            flush_req,
   input  logic            trig_in,
   input  logic            tr_valid,
   input  logic [FA_W-1:0] wlo,
   input  logic [CW-1:0]   trig_load,
   output logic            tr_ready,
   output logic            pad_we,
   output logic            stopped,
   output logic            flush_busy
);

   fmt_state_e    st_q;
   logic [CW-1:0] cnt_q;
   logic          seen_q, flush_q, stop_after_q;
   logic          trig_done, aligned, last_pad, accept, want_stop;

   assign trig_done  = cfg.stop_tr & seen_q & (cnt_q == '0);
   assign aligned    = (wlo == '0);
   assign last_pad   = &wlo;
   assign want_stop  = trig_done | (flush_q & cfg.stop_fl);
   assign tr_ready   = ctrl_en & (st_q == FMT_RUN) & ~flush_q & ~trig_done;
   assign pad_we     = ctrl_en & (st_q == FMT_PAD);
   assign accept     = tr_valid & tr_ready;
   assign stopped    = (st_q == FMT_HALT);
   assign flush_busy = flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= FMT_HALT;
         cnt_q        <= '0;
         seen_q       <= 1'b0;
         flush_q      <= 1'b0;
         stop_after_q <= 1'b0;
      end else if (start) begin
         st_q         <= FMT_RUN;
         cnt_q        <= trig_load;
         seen_q       <= 1'b0;
         flush_q      <= 1'b0;
         stop_after_q <= 1'b0;
      end else if (!ctrl_en) begin
         st_q    <= FMT_HALT;
         flush_q <= 1'b0;
      end else begin
         unique case (st_q)
            FMT_RUN: begin
               if (trig_in) seen_q <= 1'b1;
               if (accept && seen_q && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
               if (flush_req) flush_q <= 1'b1;
               if (flush_q || trig_done) begin
                  if (cfg.fmt_en && !aligned) begin
                     st_q         <= FMT_PAD;
                     stop_after_q <= want_stop;
                  end else begin
                     flush_q <= 1'b0;
                     if (want_stop) st_q <= FMT_HALT;
                  end
               end
            end
            FMT_PAD: begin
               if (flush_req) flush_q <= 1'b1;
               if (last_pad) begin
                  flush_q <= 1'b0;
                  st_q    <= stop_after_q ? FMT_HALT : FMT_RUN;
               end
            end
            default: flush_q <= 1'b0;
         endcase
      end
   end

   AST_HALT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FMT_HALT && $past(st_q) != FMT_HALT && $past(ctrl_en) && ctrl_en
       && $past(cfg.fmt_en)) |-> wlo == '0); // R9

   AST_FLUSH_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && !ctrl_en) |=> !flush_q); // R13

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CW'(1))); // R7

endmodule

// File: rtl/trs_regs.sv
module trs_regs
   import trs_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int CW    = 16,
   parameter int FA_W  = 2,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [31:0]       ram_rdata,
   input  logic              cap_we,
   input  logic [31:0]       cap_data,
   input  logic              pad_we,
   input  logic              stopped,
   input  logic              flush_busy,
   output logic              ram_we,
   output logic [AW-1:0]     ram_waddr,
   output logic [31:0]       ram_wdata,
   output logic [AW-1:0]     ram_raddr,
   output logic              ctrl_en,
   output logic              start,
   output fmt_cfg_t          cfg,
   output logic              flush_req_sw,
   output logic [CW-1:0]     trig_load,
   output logic [FA_W-1:0]   wlo
);

   localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);
   localparam bit            IS_POW2  = (DEPTH & (DEPTH - 1)) == 0;

   logic [AW-1:0] wptr_q, rptr_q, wptr_inc, rptr_inc, wptr_ld, rptr_ld;
   logic          full_q, ctrl_q;
   logic [CW-1:0] tcnt_q;
   fmt_cfg_t      cfg_q;
   logic          wr_wptr, wr_rptr, wr_ctrl, wr_tcnt, wr_fctrl, wr_wdat;
   logic          rd_data, trace_we, sw_we;

   assign wr_wptr  = bus_sel & bus_wr & (bus_addr == OFS_WPTR);
   assign wr_rptr  = bus_sel & bus_wr & (bus_addr == OFS_RPTR);
   assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == OFS_CTRL);
   assign wr_tcnt  = bus_sel & bus_wr & (bus_addr == OFS_TCNT);
   assign wr_fctrl = bus_sel & bus_wr & (bus_addr == OFS_FCTRL);
   assign wr_wdat  = bus_sel & bus_wr & (bus_addr == OFS_WDAT);
   assign rd_data  = bus_sel & ~bus_wr & (bus_addr == OFS_RDAT);

   assign trace_we = cap_we | pad_we;
   assign sw_we    = wr_wdat & ~ctrl_q;

   // pointer stepping and loading: free wrap for power-of-two depths
   generate
      if (IS_POW2) begin : g_pow2
         assign wptr_inc = wptr_q + AW'(1);
         assign rptr_inc = rptr_q + AW'(1);
         assign wptr_ld  = bus_wdata[AW-1:0];
         assign rptr_ld  = bus_wdata[AW-1:0];
      end else begin : g_npow2
         assign wptr_inc = (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
         assign rptr_inc = (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
         assign wptr_ld  = (bus_wdata < 32'(DEPTH)) ? bus_wdata[AW-1:0] : '0;
         assign rptr_ld  = (bus_wdata < 32'(DEPTH)) ? bus_wdata[AW-1:0] : '0;
      end
   endgenerate

   assign start        = wr_ctrl & bus_wdata[0] & ~ctrl_q;
   assign flush_req_sw = wr_fctrl & bus_wdata[FC_FLUSH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         full_q <= 1'b0;
         ctrl_q <= 1'b0;
         tcnt_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (trace_we || sw_we)      wptr_q <= wptr_inc;
         else if (wr_wptr && !ctrl_q) wptr_q <= wptr_ld;

         if (rd_data)      rptr_q <= rptr_inc;
         else if (wr_rptr) rptr_q <= rptr_ld;

         if (start)                          full_q <= 1'b0;
         else if (trace_we && wptr_q == LAST) full_q <= 1'b1;

         if (wr_ctrl) ctrl_q <= bus_wdata[0];
         if (wr_tcnt) tcnt_q <= bus_wdata[CW-1:0];
         if (wr_fctrl) begin
            cfg_q.fmt_en  <= bus_wdata[FC_EN];
            cfg_q.stop_fl <= bus_wdata[FC_STOPFL];
            cfg_q.stop_tr <= bus_wdata[FC_STOPTR];
         end
      end
   end

   assign ram_we    = trace_we | sw_we;
   assign ram_waddr = wptr_q;
   assign ram_wdata = pad_we ? '0 : (cap_we ? cap_data : bus_wdata);
   assign ram_raddr = rptr_q;
   assign ctrl_en   = ctrl_q;
   assign cfg       = cfg_q;
   assign trig_load = tcnt_q;
   assign wlo       = wptr_q[FA_W-1:0];

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_DEPTH: bus_rdata = 32'(DEPTH);
         OFS_STAT:  bus_rdata[0] = full_q;
         OFS_RDAT:  bus_rdata = ram_rdata;
         OFS_RPTR:  bus_rdata = 32'(rptr_q);
         OFS_WPTR:  bus_rdata = 32'(wptr_q);
         OFS_TCNT:  bus_rdata = 32'(tcnt_q);
         OFS_CTRL:  bus_rdata[0] = ctrl_q;
         OFS_FSTAT: bus_rdata[FS_STOPPED] = stopped;
         OFS_FCTRL: begin
            bus_rdata[FC_EN]     = cfg_q.fmt_en;
            bus_rdata[FC_FLUSH]  = flush_busy;
            bus_rdata[FC_STOPFL] = cfg_q.stop_fl;
            bus_rdata[FC_STOPTR] = cfg_q.stop_tr;
         end
         default:   bus_rdata = '0;
      endcase
   end

   AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !start) |=> full_q); // R5

   AST_WPTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q && !cap_we && !pad_we) |=> $stable(wptr_q)); // R3

   AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel) |=> $stable(rptr_q)); // R3

endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
   import trs_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int FRAME = 4,
   parameter int CW    = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int FA_W = $clog2(FRAME)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tr_valid,
   input  logic [31:0]       tr_data,
   output logic              tr_ready,
   input  logic              trig_in,
   input  logic              flush_in
);

   generate
      if (FRAME < 2 || (FRAME & (FRAME - 1)) != 0) begin : g_bad_frame
         $error("FRAME must be a power of two of at least 2");
      end
      if (DEPTH % FRAME != 0 || DEPTH < 2 * FRAME) begin : g_bad_depth
         $error("DEPTH must be a multiple of FRAME and hold two frames");
      end
      if (CW < 1 || CW > 31) begin : g_bad_cw
         $error("CW must lie between 1 and 31");
      end
   endgenerate

   logic            ram_we, ctrl_en, start, flush_req_sw, pad_we, stopped, flush_busy;
   logic [AW-1:0]   ram_waddr, ram_raddr;
   logic [31:0]     ram_wdata, ram_rdata;
   logic [CW-1:0]   trig_load;
   logic [FA_W-1:0] wlo;
   fmt_cfg_t        cfg;

   trs_regs #(.DEPTH(DEPTH), .CW(CW), .FA_W(FA_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .ram_rdata    (ram_rdata),
      .cap_we       (tr_valid & tr_ready),
      .cap_data     (tr_data),
      .pad_we       (pad_we),
      .stopped      (stopped),
      .flush_busy   (flush_busy),
      .ram_we       (ram_we),
      .ram_waddr    (ram_waddr),
      .ram_wdata    (ram_wdata),
      .ram_raddr    (ram_raddr),
      .ctrl_en      (ctrl_en),
      .start        (start),
      .cfg          (cfg),
      .flush_req_sw (flush_req_sw),
      .trig_load    (trig_load),
      .wlo          (wlo)
   );

   trs_fmt #(.CW(CW), .FA_W(FA_W)) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_en    (ctrl_en),
      .start      (start),
      .cfg        (cfg),
      .flush_req  (flush_req_sw | flush_in),
      .trig_in    (trig_in),
      .tr_valid   (tr_valid),
      .wlo        (wlo),
      .trig_load  (trig_load),
      .tr_ready   (tr_ready),
      .pad_we     (pad_we),
      .stopped    (stopped),
      .flush_busy (flush_busy)
   );

   trs_ram #(.DEPTH(DEPTH), .DW(32)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .raddr (ram_raddr),
      .rdata (ram_rdata)
   );

   AST_READY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      tr_ready |-> ctrl_en && !stopped); // R12

   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pad_we |-> !(tr_valid && tr_ready)); // R9

endmodule

// File: tb/test_trace_ring_sink.sv
`timescale 1ns/1ps
module test_trace_ring_sink;

   localparam int D = 16;
   localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDAT = 12'h010,
                           A_RPTR = 12'h014, A_WPTR = 12'h018, A_TCNT = 12'h01C,
                           A_CTRL = 12'h020, A_WDAT = 12'h024, A_FSTAT = 12'h300,
                           A_FCTRL = 12'h304;
   localparam logic [31:0] F_EN = 32'h1, F_FLUSH = 32'h40, F_STOPFL = 32'h1000,
                           F_STOPTR = 32'h2000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_sel = 0, bus_wr = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        tr_valid = 0, trig_in = 0, flush_in = 0, tr_ready;
   logic [31:0] tr_data = '0;

   int nchk = 0, nerr = 0;
   int seq_id = 0;
   logic [31:0] data_base = '0;

   always #10 clk = ~clk;

   trace_ring_sink #(.DEPTH(D), .FRAME(4), .CW(16)) i_trace_ring_sink (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tr_valid(tr_valid), .tr_data(tr_data), .tr_ready(tr_ready),
      .trig_in(trig_in), .flush_in(flush_in)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; #1 d = bus_rdata;
      @(negedge clk); bus_sel = 0;
   endtask

   task automatic offer(input int want, input int budget, output int got);
      got = 0;
      for (int c = 0; c < budget && got < want; c++) begin
         @(negedge clk);
         tr_valid = 1; tr_data = data_base + 32'(seq_id);
         #1;
         if (tr_ready) begin got++; seq_id++; end
      end
      @(negedge clk); tr_valid = 0;
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig_in = 1;
      @(negedge clk); trig_in = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int got;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      #1 chk("R1 ready", 32'(tr_ready), 32'd0);
      bus_read(A_STAT, v);  chk("R1 wrap", v, 32'd0);
      bus_read(A_FSTAT, v); chk("R1 stopped", v[1], 1'b1);
      bus_read(A_WPTR, v);  chk("R1 wptr", v, 32'd0);
      bus_read(A_RPTR, v);  chk("R1 rptr", v, 32'd0);
      bus_read(A_CTRL, v);  chk("R1 ctrl", v, 32'd0);

      // R2 depth read-only
      bus_read(A_DEPTH, v); chk("R2 depth", v, 32'(D));
      bus_write(A_DEPTH, 32'h55);
      bus_read(A_DEPTH, v); chk("R2 depth after write", v, 32'(D));

      // R3 software access with wrap on both pointers
      bus_write(A_WPTR, 32'd14);
      for (int i = 0; i < 3; i++) bus_write(A_WDAT, 32'hC0DE_0000 + 32'(i));
      bus_read(A_WPTR, v); chk("R3 wptr wrap", v, 32'd1);
      bus_write(A_RPTR, 32'd14);
      for (int i = 0; i < 3; i++) begin
         bus_read(A_RDAT, v); chk("R3 read data", v, 32'hC0DE_0000 + 32'(i));
      end
      bus_read(A_RPTR, v); chk("R3 rptr wrap", v, 32'd1);

      // R4 / R5 capture past the end of the ring, no formatter stops
      bus_write(A_WPTR, 32'd0);
      bus_write(A_FCTRL, 32'd0);
      bus_write(A_CTRL, 32'd1);
      bus_write(A_WPTR, 32'd9);   // ignored while armed (R3)
      bus_read(A_WPTR, v); chk("R3 wptr locked", v, 32'd0);
      data_base = 32'hA500_0000; seq_id = 0;
      offer(3, 10, got); chk("R4 accepted", 32'(got), 32'd3);
      bus_read(A_STAT, v); chk("R5 no wrap yet", v, 32'd0);
      offer(18, 40, got); chk("R4 accepted more", 32'(got), 32'd18);
      bus_read(A_STAT, v); chk("R5 wrap set", v, 32'd1);
      bus_read(A_WPTR, v); chk("R4 wptr", v, 32'd5);
      bus_write(A_CTRL, 32'd0);
      #1 chk("R12 ready low", 32'(tr_ready), 32'd0);
      bus_read(A_FSTAT, v); chk("R12 stopped", v[1], 1'b1);
      bus_read(A_STAT, v); chk("R5 wrap held", v, 32'd1);
      bus_write(A_RPTR, 32'd5);
      for (int i = 0; i < D; i++) begin
         bus_read(A_RDAT, v); chk("R5 oldest-first drain", v, 32'hA500_0000 + 32'(5 + i));
      end
      bus_write(A_CTRL, 32'd1);
      bus_read(A_STAT, v);  chk("R6 wrap cleared", v, 32'd0);
      bus_read(A_FSTAT, v); chk("R6 stopped cleared", v[1], 1'b0);

      // R7 sweep: start offset within a frame x post-trigger count
      data_base = 32'h7700_0000;
      for (int off = 0; off < 4; off++) begin
         for (int n = 0; n < 7; n++) begin
            int e;
            bus_write(A_CTRL, 32'd0);
            bus_write(A_WPTR, 32'(off));
            bus_write(A_TCNT, 32'(n));
            bus_write(A_FCTRL, F_EN | F_STOPTR);
            bus_write(A_CTRL, 32'd1);
            offer(2, 6, got);
            pulse_trig();
            offer(20, 30, got); chk("R7 words after trigger", 32'(got), 32'(n));
            idle(8);
            e = ((off + 2 + n + 3) / 4) * 4 % D;
            bus_read(A_WPTR, v);  chk("R7 aligned stop pointer", v, 32'(e));
            bus_read(A_FSTAT, v); chk("R7 stopped", v[1], 1'b1);
         end
      end

      // R8 trigger without stop-on-trigger
      bus_write(A_CTRL, 32'd0);
      bus_write(A_WPTR, 32'd0);
      bus_write(A_TCNT, 32'd1);
      bus_write(A_FCTRL, F_EN);
      bus_write(A_CTRL, 32'd1);
      pulse_trig();
      offer(6, 10, got); chk("R8 trigger ignored", 32'(got), 32'd6);
      bus_read(A_FSTAT, v); chk("R8 not stopped", v[1], 1'b0);

      // R9 / R10 software flush with stop, zero fill over stale words
      bus_write(A_CTRL, 32'd0);
      bus_write(A_WPTR, 32'd0);
      for (int i = 0; i < 4; i++) bus_write(A_WDAT, 32'hFFFF_0000 + 32'(i));
      bus_write(A_WPTR, 32'd0);
      bus_write(A_FCTRL, F_EN | F_STOPFL);
      bus_write(A_CTRL, 32'd1);
      offer(1, 4, got);
      bus_write(A_FCTRL, F_EN | F_STOPFL | F_FLUSH);
      bus_read(A_FCTRL, v); chk("R9 flush busy", v[6], 1'b1);
      idle(10);
      bus_read(A_FCTRL, v); chk("R9 flush cleared", v[6], 1'b0);
      bus_read(A_FSTAT, v); chk("R10 stopped after flush", v[1], 1'b1);
      bus_read(A_WPTR, v);  chk("R9 padded pointer", v, 32'd4);
      offer(3, 6, got); chk("R10 refuses after stop", 32'(got), 32'd0);
      bus_write(A_CTRL, 32'd0);
      bus_write(A_RPTR, 32'd1);
      for (int i = 0; i < 3; i++) begin
         bus_read(A_RDAT, v); chk("R9 pad word zero", v, 32'd0);
      end

      // R10 flush from the pin without stop: capture resumes
      bus_write(A_WPTR, 32'd5);
      bus_write(A_FCTRL, F_EN);
      bus_write(A_CTRL, 32'd1);
      offer(1, 4, got);
      @(negedge clk); flush_in = 1;
      @(negedge clk); flush_in = 0;
      idle(8);
      bus_read(A_WPTR, v);  chk("R9 pin flush pad", v, 32'd8);
      bus_read(A_FSTAT, v); chk("R10 still running", v[1], 1'b0);
      offer(3, 10, got); chk("R10 resumed", 32'(got), 32'd3);
      bus_read(A_WPTR, v);  chk("R10 pointer", v, 32'd11);

      // R11 formatting disabled: stop on flush without zero fill
      bus_write(A_CTRL, 32'd0);
      bus_write(A_WPTR, 32'd1);
      bus_write(A_FCTRL, F_STOPFL | F_STOPTR);
      bus_write(A_CTRL, 32'd1);
      offer(1, 4, got);
      bus_write(A_FCTRL, F_STOPFL | F_STOPTR | F_FLUSH);
      idle(6);
      bus_read(A_FSTAT, v); chk("R11 stopped", v[1], 1'b1);
      bus_read(A_WPTR, v);  chk("R11 no fill", v, 32'd2);

      // R13 flush while disarmed
      bus_write(A_CTRL, 32'd0);
      bus_write(A_FCTRL, F_EN | F_FLUSH);
      bus_read(A_FCTRL, v); chk("R13 flush done at once", v[6], 1'b0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule